// File: doc/BRIEF.md
# Hashed Presence-Tracked Inter-Stage Buffer

This block connects two pipeline stages that handle the elements of one array in different orders. The producing stage writes element `k` with its value. The consuming stage asks for element `k` and gets either the value or a miss. After a miss the consumer keeps the same address and asks again on a later cycle. This lets a consumer that reads out of order start before the producer has finished, which a plain FIFO cannot do.

Each storage cell has a small read counter beside it. The counter is a thermometer field `READS` bits wide. A write fills it with ones, and every successful read shifts it right by one. A cell with a zero field is empty. The cell is picked by folding the logical address modulo `2**HASH_W`, which means keeping its low `HASH_W` bits with no extra logic. Because of this fold, the buffer can be much smaller than the array. A write that lands on a cell still holding unread data is refused and flagged as a collision, and the producer must retry.

Top module: `hashed_presence_buffer`

## Requirements
- R1: When the producer writes each of the 64 indices of an 8x8 block in column order, and the consumer reads them in row order with `READS` reads per element, every hit returns the value written for that logical index and no collision occurs when `2**HASH_W` >= 64.
- R2: After reset every cell is empty, so any read request misses.
- R3: The cell index is the low `HASH_W` bits of the address. Two logical addresses that differ only above those bits share one cell, and no tag check is made, so a read of either address returns that cell's state and data.
- R4: A write to an empty cell stores the data and marks the cell full with `READS` reads remaining. A read of that cell on the next cycle hits.
- R5: Each hit returns the stored data and uses up one read. After `READS` hits the cell is empty and further reads miss.
- R6: A write to a cell with reads remaining raises `wr_collide` in the same cycle and changes neither the cell's data nor its remaining reads.
- R7: A read and a write to the same empty cell in one cycle: the read misses and the written data becomes readable on the next cycle. A read and a write to different cells in one cycle are both serviced.
- R8: `rd_hit` and `rd_data` respond in the same cycle as `rd_req`. `rd_hit` is never high without `rd_req`, and `rd_data` is zero whenever `rd_hit` is low.
- R9: The collision decision uses the cell state at the start of the cycle. A write to a cell whose last read happens in that same cycle is refused, and the read still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; empties all cells |
| wr_valid | input | 1 | Producer write strobe |
| wr_addr | input | ADDR_W | Producer logical index |
| wr_data | input | DATA_W | Producer value |
| wr_collide | output | 1 | Write refused: target cell still holds unread data |
| rd_req | input | 1 | Consumer read request |
| rd_addr | input | ADDR_W | Consumer logical index |
| rd_data | output | DATA_W | Value of the addressed cell on a hit, zero otherwise |
| rd_hit | output | 1 | Addressed cell held data (high) or was empty (low) |

## Verification
The assertions check four things on every cycle:
- an accepted write leaves its cell fully loaded;
- a hit removes exactly one read;
- a refused write leaves the stored value unchanged;
- the counter of any addressed cell is always a thermometer code.

Other behaviour can only be shown by the bench's scenarios. These are the out-of-order block transfer keeping values tied to logical indices, the fold of high addresses onto shared cells, and the same-cycle orderings of a write against a read of the same cell, both on an empty cell and on a cell taking its last read.

// File: rtl/hashed_presence_buffer.sv
module hashed_presence_buffer #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int HASH_W = 6,
  parameter int READS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_collide,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit
);
  localparam int DEPTH = 1 << HASH_W;

  logic [READS-1:0]  fill [DEPTH];
  logic [DATA_W-1:0] mem  [DEPTH];
  logic [HASH_W-1:0] wh, rh;
  logic              wr_take;

  assign wh         = wr_addr[HASH_W-1:0];
  assign rh         = rd_addr[HASH_W-1:0];
  assign wr_collide = wr_valid && (fill[wh] != '0);
  assign wr_take    = wr_valid && !wr_collide;
  assign rd_hit     = rd_req && (fill[rh] != '0);
  assign rd_data    = rd_hit ? mem[rh] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) fill[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_take && wh == HASH_W'(i))
          fill[i] <= '1;
        else if (rd_hit && rh == HASH_W'(i))
          fill[i] <= fill[i] >> 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take) mem[wh] <= wr_data;
  end

  a_r4_write_loads_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> fill[$past(wh)] == {READS{1'b1}});

  a_r5_hit_uses_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !(wr_take && wh == rh)) |=> fill[$past(rh)] == ($past(fill[rh]) >> 1));

  a_r6_collide_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    wr_collide |=> mem[$past(wh)] == $past(mem[wh]));

  a_r5_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ((fill[rh] & (fill[rh] + 1'b1)) == '0));
endmodule

// File: tb/test_hashed_presence_buffer.sv
module test_hashed_presence_buffer;
  localparam int PERIOD = 10;
  localparam int DW = 16, AW = 8, HW = 6, RD = 2;
  localparam int M = 1 << HW;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_req = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic wr_collide, rd_hit;
  logic [DW-1:0] rd_data;

  int checks = 0, fails = 0;
  int left [M];
  int val  [M];
  bit e_col, e_hit;
  int e_dat;

  always #(PERIOD/2) clk = ~clk;

  hashed_presence_buffer #(.DATA_W(DW), .ADDR_W(AW), .HASH_W(HW), .READS(RD)) i_hashed_presence_buffer (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_collide(wr_collide), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_hit(rd_hit));

  function automatic int fval(int idx);
    return (idx * 37 + 5) & 16'hFFFF;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, compare model outputs, advance model at posedge
  task automatic step(bit wv, int wa, int wd, bit rq, int ra, string req);
    wr_valid = wv; wr_addr = AW'(wa); wr_data = DW'(wd);
    rd_req = rq; rd_addr = AW'(ra);
    e_col = wv && left[wa % M] > 0;
    e_hit = rq && left[ra % M] > 0;
    e_dat = e_hit ? val[ra % M] : 0;
    #1;
    chk({req, " collide"}, int'(wr_collide), int'(e_col));
    chk({req, " hit"}, int'(rd_hit), int'(e_hit));
    chk({req, " data R8"}, int'(rd_data), e_dat);
    @(posedge clk);
    if (e_hit) left[ra % M]--;
    if (wv && !e_col) begin left[wa % M] = RD; val[wa % M] = wd; end
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < M; i++) begin left[i] = 0; val[i] = 0; end
    @(negedge clk); @(negedge clk);
    step(0, 0, 0, 1, 5, "R2 reset");
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < M; a += 9) step(0, 0, 0, 1, a, "R2 empty");

    // R1: 8x8 transfer, producer column order, consumer row order, READS reads each
    begin
      int p = 0, c = 0, got = 0, cyc = 0, idx;
      bit col_seen = 0;
      while (c < 64 && cyc < 2000) begin
        idx = (p % 8) * 8 + p / 8;
        step(p < 64, idx, fval(idx), 1, c, "R1 transfer");
        if (e_col) col_seen = 1;
        if (e_hit) begin
          chk("R1 value", e_dat, fval(c));
          got++;
          if (got == RD) begin got = 0; c++; end
        end
        if (p < 64 && !e_col) p++;
        cyc++;
      end
      chk("R1 all consumed", c, 64);
      chk("R1 no collision", int'(col_seen), 0);
    end

    // R4/R5: write, read RD times, then miss
    step(1, 3, 111, 0, 0, "R4 write");
    step(0, 0, 0, 1, 3, "R4 read1");
    step(1, 67, 222, 0, 0, "R6 collide");
    chk("R6 collide seen", int'(e_col), 1);
    step(0, 0, 0, 1, 3, "R5 read2");
    chk("R6 data kept", e_dat, 111);
    step(0, 0, 0, 1, 3, "R5 empty after reads");
    chk("R5 miss", int'(e_hit), 0);

    // R3: folded address reads shared cell
    step(1, 200, 555, 0, 0, "R3 write high");
    step(0, 0, 0, 1, 8, "R3 fold read");
    chk("R3 fold hit", e_dat, 555);
    step(0, 0, 0, 1, 136, "R3 fold read alias");

    // R7: same-cycle write and read on empty cell
    step(1, 20, 777, 1, 20, "R7 same cell");
    chk("R7 read miss", int'(e_hit), 0);
    step(1, 30, 888, 1, 20, "R7 next cycle and dual");
    chk("R7 hit", e_dat, 777);

    // R9: last read and write in same cycle
    step(1, 20, 999, 1, 20, "R9 last read with write");
    chk("R9 refused", int'(e_col), 1);
    step(1, 84, 999, 1, 30, "R9 retry");
    chk("R9 retry accepted", int'(e_col), 0);
    step(0, 0, 0, 1, 20, "R9 new data");
    chk("R9 data", e_dat, 999);

    // R8: no request means no hit
    step(0, 0, 0, 0, 20, "R8 idle");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule